// File: doc/BRIEF.md
# Polled SPI Master with Two-Stage Clock Divider

This block is a single-chip-select SPI master that a processor runs entirely by polling over a 32-bit word bus. Software picks the serial clock rate, polarity and phase in a configuration register. It then writes one byte to the transmit register, which starts an 8-bit full-duplex exchange. It waits for the busy flag to drop, and collects the received byte from the receive register.

The serial clock comes from the bus clock through two divider stages. The first stage is a coarse prescaler of 16 or 128. The second stage divides by twice (N+1), where N is a 5-bit field. The chip-select pin is not generated per frame. It simply follows a level bit that software writes, so a multi-byte transaction stays selected for as long as software wants.

A transfer only starts while the master-enable bit of the system register is set. Writing 0x21 to the system register enables the master and asserts chip select in a single write.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset, the config register (0x00) reads 0 and the status register (0x04) reads 0. The system register (0x08) reads 0x40, `cs_n` is 1 and `sck` is 0.
- R2: Register readback works as follows. Bits 7:0 of 0x00, 0x08 and 0x0C read back what was last written to them, with bits 31:8 reading 0. The scratch register at 0x14 reads back all 32 bits.
- R3: A frame toggles `sck` exactly 16 times. Consecutive toggles are H bus cycles apart, and the first toggle comes H cycles after the write to 0x0C. H = P×(N+1), where N = config[4:0], and P = 128 when config[5] = 1 and 16 when it is 0.
- R4: While no frame is running, `sck` equals config[6] (clock polarity).
- R5: Data leaves on `mosi` MSB first. With config[7] (phase) = 0, each bit is valid before the leading edge and held until the trailing edge. With phase = 1, each bit changes on the leading edge and is held through the trailing edge.
- R6: `miso` is sampled on the leading edge when phase = 0 and on the trailing edge when phase = 1. The 8 bits, MSB first, are read from 0x10.
- R7: Status bit 0 (busy) reads 1 from the cycle after the write to 0x0C that starts a frame, up to the 16th `sck` toggle. It reads 0 from that toggle onward.
- R8: Status bit 2 (receive-full) becomes 1 when a frame completes. It is cleared by a read of 0x10, or by a write to 0x04 with bit 2 = 0. The other status bits read 0.
- R9: A write to 0x0C while busy is ignored. The running frame and the 0x0C readback are unchanged.
- R10: A write to 0x0C while system register bit 0 (master enable) is 0 stores the byte but starts no frame: busy stays 0 and `sck` does not move.
- R11: `cs_n` follows system register bit 6 (0 = asserted low, 1 = high) at all times, independent of frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Byte address of the word register |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (drives the read side effects) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Chip select, software level |

## Verification
The bench acts as the serial slave. It sweeps all four clock modes across several data patterns and both prescaler settings, and measures the spacing of every serial-clock edge against P×(N+1). A divider that is off by one, or that counts N instead of N+1, shows up as wrong spacing. A swapped phase decode shows up as a shifted byte on either side, and a stale sample on the final edge corrupts the LSB of the received byte. The bench also writes the transmit register in the middle of a frame and without master enable. A design that accepts either write would change the byte on the wire or produce clock edges where none are allowed. Busy is compared on every cycle of each frame, so a flag that drops one cycle early or late is caught.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_CFG  = 5'h00;
  localparam logic [ADDR_W-1:0] A_STAT = 5'h04;
  localparam logic [ADDR_W-1:0] A_SYS  = 5'h08;
  localparam logic [ADDR_W-1:0] A_TX   = 5'h0C;
  localparam logic [ADDR_W-1:0] A_RX   = 5'h10;
  localparam logic [ADDR_W-1:0] A_AUX  = 5'h14;

  // config byte layout; field positions matter to software
  typedef struct packed {
    logic       cpha;    // bit 7
    logic       cpol;    // bit 6
    logic       coarse;  // bit 5
    logic [4:0] n;       // bits 4:0
  } spi_cfg_t;

  // bus cycles between consecutive sck toggles
  function automatic int unsigned half_period(input logic coarse, input logic [4:0] n,
                                              input int unsigned pre_lo, input int unsigned pre_hi);
    return (coarse ? pre_hi : pre_lo) * (int'(n) + 1);
  endfunction

  // received byte as seen on the final edge of a frame
  function automatic logic [7:0] final_rx(input logic cpha, input logic [7:0] sr, input logic in_bit);
    return cpha ? {sr[6:0], in_bit} : sr;
  endfunction

endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div
  import spi_host_pkg::*;
#(
  parameter int unsigned PRE_LO = 16,
  parameter int unsigned PRE_HI = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       coarse,
  input  logic [4:0] n,
  output logic       tick
);
  localparam int unsigned MAX_HALF = PRE_HI * 32;
  localparam int CNT_W = $clog2(MAX_HALF);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  always_comb limit = CNT_W'(half_period(coarse, n, PRE_LO, PRE_HI) - 1);

  assign tick = run && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!run || tick)     cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_host_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  spi_cfg_t   cfg_in,
  input  logic       tick,
  input  logic       miso,
  output spi_cfg_t   cfg_q,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       sck,
  output logic       mosi
);
  logic       busy_q, phase_q, mosi_q;
  logic [3:0] edge_q;
  logic [7:0] tx_sr, rx_sr;
  logic       leading, last_edge, sample_now, shift_now;

  assign leading    = ~edge_q[0];
  assign last_edge  = (edge_q == 4'd15);
  assign sample_now = tick && (leading ^ cfg_q.cpha);
  assign shift_now  = tick && !(leading ^ cfg_q.cpha) && !last_edge;
  assign done       = tick && last_edge;

  assign busy    = busy_q;
  assign mosi    = mosi_q;
  assign sck     = busy_q ? (cfg_q.cpol ^ phase_q) : cfg_in.cpol;
  assign rx_byte = final_rx(cfg_q.cpha, rx_sr, miso);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      mosi_q  <= 1'b0;
      edge_q  <= '0;
      tx_sr   <= '0;
      rx_sr   <= '0;
      cfg_q   <= '0;
    end else if (start) begin
      busy_q  <= 1'b1;
      phase_q <= 1'b0;
      edge_q  <= '0;
      cfg_q   <= cfg_in;
      rx_sr   <= '0;
      if (!cfg_in.cpha) begin
        mosi_q <= tx_byte[7];
        tx_sr  <= {tx_byte[6:0], 1'b0};
      end else begin
        tx_sr  <= tx_byte;
      end
    end else if (busy_q && tick) begin
      phase_q <= ~phase_q;
      edge_q  <= edge_q + 1'b1;
      if (sample_now) rx_sr <= {rx_sr[6:0], miso};
      if (shift_now) begin
        mosi_q <= tx_sr[7];
        tx_sr  <= {tx_sr[6:0], 1'b0};
      end
      if (last_edge) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
  import spi_host_pkg::*;
#(
  parameter int unsigned PRE_LO = 16,
  parameter int unsigned PRE_HI = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_n
);
  localparam logic [7:0] SYS_RST = 8'h40;

  logic [7:0]        cfg_reg_q, sys_q, tx_q, rx_q;
  logic [DATA_W-1:0] aux_q;
  logic              rx_full_q;

  spi_cfg_t   cfg_live, cfg_run;
  logic       eng_busy, eng_done, div_tick, start_req;
  logic [7:0] eng_rx;

  logic wr_cfg, wr_stat, wr_sys, wr_tx, wr_aux, rd_rx;

  assign cfg_live = spi_cfg_t'(cfg_reg_q);
  assign wr_cfg   = bus_we && bus_addr == A_CFG;
  assign wr_stat  = bus_we && bus_addr == A_STAT;
  assign wr_sys   = bus_we && bus_addr == A_SYS;
  assign wr_tx    = bus_we && bus_addr == A_TX && !eng_busy;
  assign wr_aux   = bus_we && bus_addr == A_AUX;
  assign rd_rx    = bus_re && bus_addr == A_RX;
  assign start_req = wr_tx && sys_q[0];
  assign cs_n     = sys_q[6];

  spi_clk_div #(.PRE_LO(PRE_LO), .PRE_HI(PRE_HI)) div_i (
    .clk(clk), .rst_n(rst_n), .run(eng_busy),
    .coarse(cfg_run.coarse), .n(cfg_run.n), .tick(div_tick)
  );

  spi_shift_engine eng_i (
    .clk(clk), .rst_n(rst_n), .start(start_req), .tx_byte(bus_wdata[7:0]),
    .cfg_in(cfg_live), .tick(div_tick), .miso(miso), .cfg_q(cfg_run),
    .busy(eng_busy), .done(eng_done), .rx_byte(eng_rx), .sck(sck), .mosi(mosi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_reg_q <= '0;
      sys_q     <= SYS_RST;
      tx_q      <= '0;
      rx_q      <= '0;
      aux_q     <= '0;
      rx_full_q <= 1'b0;
    end else begin
      if (wr_cfg) cfg_reg_q <= bus_wdata[7:0];
      if (wr_sys) sys_q     <= bus_wdata[7:0];
      if (wr_tx)  tx_q      <= bus_wdata[7:0];
      if (wr_aux) aux_q     <= bus_wdata;
      if (eng_done) begin
        rx_q      <= eng_rx;
        rx_full_q <= 1'b1;
      end else if (rd_rx || (wr_stat && !bus_wdata[2])) begin
        rx_full_q <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_CFG:   bus_rdata[7:0] = cfg_reg_q;
      A_STAT:  bus_rdata[2:0] = {rx_full_q, 1'b0, eng_busy};
      A_SYS:   bus_rdata[7:0] = sys_q;
      A_TX:    bus_rdata[7:0] = tx_q;
      A_RX:    bus_rdata[7:0] = rx_q;
      A_AUX:   bus_rdata      = aux_q;
      default: bus_rdata      = '0;
    endcase
  end
endmodule

// File: rtl/spi_host_ctrl_chk.sv
module spi_host_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       tick,
  input logic       sck,
  input logic       cpol,
  input logic       master,
  input logic       rx_full,
  input logic [7:0] tx_q
);
  a_r7_busy_until_last_edge: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy);

  a_r4_idle_sck_is_cpol: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck == cpol);

  a_r3_sck_moves_on_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !tick |=> $stable(sck));

  a_r9_tx_locked_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(tx_q));

  a_r10_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !master |=> !busy);

  a_r8_full_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> rx_full);
endmodule

bind spi_host_ctrl spi_host_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .busy(eng_busy), .done(eng_done), .tick(div_tick),
  .sck(sck), .cpol(cfg_reg_q[6]), .master(sys_q[0]), .rx_full(rx_full_q), .tx_q(tx_q)
);

// File: tb/spi_host_ctrl_tb.sv
`timescale 1ns/1ps
module spi_host_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [31:0] wd = '0;
  logic [31:0] rdata;
  logic        sck, mosi, cs_n;
  logic        miso = 1'b0;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  spi_host_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_re(re),
    .bus_wdata(wd), .bus_rdata(rdata), .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bw(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; we = 1'b1; wd = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic br(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; re = 1'b1;
    #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  // one frame with the bench as serial slave; inj writes the tx register mid-frame
  task automatic run_frame(input logic [7:0] cfg, input logic [7:0] txb,
                           input logic [7:0] slb, input bit inj);
    int h, edges, since, bad_sp, bad_busy, guard;
    bit skip;
    logic prev;
    logic [7:0] got;
    logic [31:0] d;
    h = ((cfg[5]) ? 128 : 16) * (int'(cfg[4:0]) + 1);
    bw(5'h00, {24'h0, cfg});
    miso = slb[7];
    bw(5'h0C, {24'h0, txb});
    addr = 5'h04;
    edges = 0; since = 0; bad_sp = 0; bad_busy = 0; guard = 0; skip = 1'b1;
    got = '0; prev = sck;
    while (edges < 16 && guard < 70000) begin
      @(negedge clk);
      guard++; since++;
      if (we) begin we = 1'b0; addr = 5'h04; end
      if (sck !== prev) begin
        int e;
        e = edges;
        prev = sck;
        if (since != h) bad_sp++;
        since = 0;
        edges++;
        if ((e % 2 == 0) != cfg[7]) got = {got[6:0], mosi};
        else if (!cfg[7]) begin
          if (e / 2 < 7) miso = slb[6 - e/2];
        end else miso = slb[7 - e/2];
      end
      if (!skip && rdata[0] !== (edges < 16)) bad_busy++;
      skip = 1'b0;
      if (inj && edges == 5 && since == 1) begin
        addr = 5'h0C; we = 1'b1; wd = 32'hEE; skip = 1'b1;
      end
    end
    chk("R3 edge count", edges, 16);
    chk("R3 edge spacing errors", bad_sp, 0);
    chk("R7 busy mismatches", bad_busy, 0);
    chk("R5 mosi byte", got, txb);
    chk("R4 idle sck", sck, cfg[6]);
    br(5'h04, d); chk("R8 status after frame", d, 32'h4);
    br(5'h0C, d); chk("R9 tx readback", d, {24'h0, txb});
    br(5'h10, d); chk("R6 rx byte", d, {24'h0, slb});
    br(5'h04, d); chk("R8 cleared by rx read", d, 32'h0);
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 190000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=<190000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] d;
    logic s0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    br(5'h00, d); chk("R1 cfg reset", d, 0);
    br(5'h04, d); chk("R1 status reset", d, 0);
    br(5'h08, d); chk("R1 sys reset", d, 32'h40);
    chk("R1 cs_n reset", cs_n, 1);
    chk("R1 sck reset", sck, 0);
    // R2 readback
    bw(5'h00, 32'hFFFF_FF25); br(5'h00, d); chk("R2 cfg readback", d, 32'h25);
    bw(5'h14, 32'hDEAD_BE5A); br(5'h14, d); chk("R2 aux readback", d, 32'hDEAD_BE5A);
    bw(5'h00, 32'h0);
    // R10 no start without master enable
    s0 = sck;
    bw(5'h0C, 32'h3C);
    repeat (60) begin
      @(negedge clk);
      if (sck !== s0) begin n_chk++; n_fail++; $display("FAIL R10 sck moved actual=%0b expected=%0b", sck, s0); end
    end
    br(5'h04, d); chk("R10 busy stays 0", d, 0);
    br(5'h0C, d); chk("R2 tx readback", d, 32'h3C);
    // R11 chip select level
    bw(5'h08, 32'h21); chk("R11 cs_n low", cs_n, 0);
    br(5'h08, d); chk("R2 sys readback", d, 32'h21);
    bw(5'h08, 32'h61); chk("R11 cs_n high", cs_n, 1);
    bw(5'h08, 32'h21); chk("R11 cs_n low again", cs_n, 0);
    // R4 idle polarity
    bw(5'h00, 32'h40); chk("R4 sck follows cpol=1", sck, 1);
    bw(5'h00, 32'h00); chk("R4 sck follows cpol=0", sck, 0);
    // R3 R5 R6 R7 sweep: modes x divider x patterns
    for (int m = 0; m < 4; m++)
      for (int nn = 0; nn < 2; nn++)
        for (int p = 0; p < 4; p++) begin
          logic [7:0] tb, sb;
          tb = 8'(p * 37 + 5 + m * 64);
          sb = ~tb ^ 8'(p * 11 + nn);
          run_frame({m[0], m[1], 1'b0, 5'(nn)}, tb, sb, 1'b0);
        end
    run_frame(8'h20, 8'h96, 8'h1E, 1'b0);        // coarse prescaler
    run_frame(8'h82, 8'h80, 8'h01, 1'b0);        // N=2, mode phase 1
    // R9 write while busy ignored
    run_frame(8'h40, 8'hC3, 8'h5A, 1'b1);
    run_frame(8'hC0, 8'h0F, 8'hF1, 1'b1);
    // R8 clear through status write
    begin
      logic [31:0] dd;
      bw(5'h00, 32'h0);
      bw(5'h0C, 32'hAA);
      do br(5'h04, dd); while (dd[0] === 1'b1 && cyc < 180000);
      chk("R8 full after frame", dd, 32'h4);
      bw(5'h04, 32'h0);
      br(5'h04, dd); chk("R8 cleared by status write", dd, 32'h0);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule